// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the processor side of a coprocessor port. It runs the handshake for five operation kinds: moving a register value to the coprocessor, fetching a value from it, asking it to run an internal operation, loading words from memory into it, and storing words from it to memory. The sequencer presents a phase code each cycle and samples the coprocessor's two-bit reply in the same cycle. While the coprocessor is busy, the sequencer waits with idle cycles. It abandons the wait if an interrupt request becomes pending. It reports refusal as an undefined-instruction result and walks word addresses for memory transfers.

Commands arrive on a valid/ready interface. `op_ready` is high only when the sequencer is idle and is not showing a completion. A command transfers on a cycle where `op_valid` and `op_ready` are both high. The issuer may hold `op_valid` for as long as it likes, and nothing is lost while `op_ready` is low. Every command ends with a one-cycle `done` pulse that carries a result code, an interrupt cause and, for fetches, a data word. Memory is modelled as a single-cycle port. An abort on that port ends a transfer loop.

Top module: `cp_handshake_seq`

## Requirements
- R1: A command is accepted on a cycle with `op_valid` and `op_ready` both high. `op_ready` is low in every cycle where `cp_phase` is not idle and in the cycle where `done` is high. The cycle after acceptance shows phase FIRST (1), unless the command failed its address check.
- R2: Phase codes are IDLE 0, FIRST 1, BUSY 2, INTR 3, XFER 4, DATA 5. Reply codes are DONE 0, BUSY 1, CANT 2, INC 3. Operation kinds are write-to-coprocessor 0, read-from-coprocessor 1, internal 2, load 3, store 4. An internal operation whose FIRST or BUSY phase sees DONE raises `done` in the next cycle, with result OK.
- R3: A BUSY reply to a FIRST or BUSY phase is followed by exactly one cycle of phase IDLE. A BUSY phase follows that cycle unless an interrupt is pending.
- R4: If an interrupt is pending in the idle cycle of a busy wait, the next cycle shows phase INTR for one cycle. `done` then rises with result INTR (3), and no further BUSY phase is shown.
- R5: Pending is decided with this priority: `req_reset_n` low (cause 1), then `req_fast_n` low with `mask_fast` clear (cause 2), then `req_norm_n` low with `mask_norm` clear (cause 3). A masked request is ignored. Requests have no effect when no busy wait occurs. The cause is 0 for any result other than INTR.
- R6: A CANT reply to a FIRST or BUSY phase ends the command with result UNDEF (1). For a read-from-coprocessor command, `res_data` is then the top four bits set and all other bits zero.
- R7: When a write-to-coprocessor command is accepted by the coprocessor, one XFER phase drives `cp_wdata` with the command's `op_wdata`. `done` with result OK follows in the next cycle.
- R8: When a read-from-coprocessor command is accepted by the coprocessor, one XFER phase captures `cp_rdata`. One IDLE cycle follows, then `done` with result OK and `res_data` equal to the captured word.
- R9: When a load is accepted by the coprocessor, one XFER phase is followed by DATA phases. In each DATA phase, memory is read at the current address and `mem_rdata` is passed on `cp_wdata`. An INC reply advances the address by 4 and repeats the phase. Any other reply ends the load with result OK.
- R10: When a store is accepted by the coprocessor, DATA phases follow directly. Each one writes `cp_rdata` to memory at the current address, and INC advances the address by 4.
- R11: The transfer address starts at `op_addr` with its two low bits cleared. A load or store whose address has any bit at position `LIM_W` (26) or above set ends with result ABORT (2) in the cycle after acceptance, with no phase shown. A store also faults below `VEC_BYTES` (32). The store check is made again just before its data phases.
- R12: `mem_abort` high in a DATA cycle ends the transfer. `done` follows with result ABORT.
- R13: `done` is high for exactly one cycle per command. The result outputs hold their value until the next `done`. After reset, `done`, `mem_req` and `res_code` are 0, `cp_phase` is IDLE and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Command valid |
| op_ready | output | 1 | Command ready |
| op_kind | input | 3 | Operation kind |
| op_addr | input | AW | Start address for load/store |
| op_wdata | input | DW | Word sent by a write-to-coprocessor command |
| cp_phase | output | 3 | Phase presented to the coprocessor |
| cp_reply | input | 2 | Coprocessor reply for the current phase |
| cp_wdata | output | DW | Word passed to the coprocessor |
| cp_rdata | input | DW | Word offered by the coprocessor |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| mem_abort | input | 1 | Memory abort for the current access |
| req_reset_n | input | 1 | Reset request, active low |
| req_fast_n | input | 1 | Fast interrupt request, active low |
| req_norm_n | input | 1 | Normal interrupt request, active low |
| mask_fast | input | 1 | Masks the fast request |
| mask_norm | input | 1 | Masks the normal request |
| done | output | 1 | Command finished (one cycle) |
| res_code | output | 2 | Result: OK 0, UNDEF 1, ABORT 2, INTR 3 |
| res_cause | output | 2 | Interrupt cause, 0 if none |
| res_data | output | DW | Fetched word or flag-preserving value |

## Verification
On every cycle, the assertions check these local rules:
- An idle cycle separates each BUSY reply from the next BUSY phase.
- INTR, CANT and memory abort each lead to `done` with the matching code one cycle later.
- The reported cause follows the request pins sampled in the idle cycle.
- The address steps by 4 after INC.
- `done` never lasts two cycles.
- `op_ready` stays low during phases.

Only the bench scenarios can show the whole-command behaviour: end-to-end latency for each kind, the word counts and sums of load and store loops, the address faults that end a command with no phase, and the refused fetch returning the flag mask.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  localparam logic [2:0] PH_IDLE  = 3'd0;
  localparam logic [2:0] PH_FIRST = 3'd1;
  localparam logic [2:0] PH_BUSY  = 3'd2;
  localparam logic [2:0] PH_INTR  = 3'd3;
  localparam logic [2:0] PH_XFER  = 3'd4;
  localparam logic [2:0] PH_DATA  = 3'd5;

  localparam logic [1:0] RP_DONE = 2'd0;
  localparam logic [1:0] RP_BUSY = 2'd1;
  localparam logic [1:0] RP_CANT = 2'd2;
  localparam logic [1:0] RP_INC  = 2'd3;

  localparam logic [2:0] K_WRITE = 3'd0;
  localparam logic [2:0] K_READ  = 3'd1;
  localparam logic [2:0] K_INT   = 3'd2;
  localparam logic [2:0] K_LOAD  = 3'd3;
  localparam logic [2:0] K_STORE = 3'd4;

  localparam logic [1:0] RC_OK    = 2'd0;
  localparam logic [1:0] RC_UNDEF = 2'd1;
  localparam logic [1:0] RC_ABORT = 2'd2;
  localparam logic [1:0] RC_INTR  = 2'd3;

  localparam logic [1:0] CZ_NONE  = 2'd0;
  localparam logic [1:0] CZ_RESET = 2'd1;
  localparam logic [1:0] CZ_FAST  = 2'd2;
  localparam logic [1:0] CZ_NORM  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_WAIT, ST_BUSY, ST_INTR, ST_XFER, ST_TAIL, ST_DATA
  } seq_state_e;
endpackage

// File: rtl/cp_pend_arb.sv
module cp_pend_arb
  import cp_seq_pkg::*;
(
  input  logic       req_reset_n,
  input  logic       req_fast_n,
  input  logic       req_norm_n,
  input  logic       mask_fast,
  input  logic       mask_norm,
  output logic       pend_o,
  output logic [1:0] cause_o
);
  always_comb begin
    cause_o = CZ_NONE;
    if (!req_reset_n)                  cause_o = CZ_RESET;
    else if (!req_fast_n && !mask_fast) cause_o = CZ_FAST;
    else if (!req_norm_n && !mask_norm) cause_o = CZ_NORM;
  end
  assign pend_o = (cause_o != CZ_NONE);
endmodule

// File: rtl/cp_addr_unit.sv
module cp_addr_unit #(
  parameter int AW        = 32,
  parameter int LIM_W     = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          new_store_i,
  input  logic          step_i,
  input  logic          cur_store_i,
  output logic [AW-1:0] cur_o,
  output logic          fault_new_o,
  output logic          fault_cur_o
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] VEC_LIM = AW'(VEC_BYTES);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] new_al;
  logic hi_new, hi_cur;

  assign new_al = {addr_i[AW-1:2], 2'b00};

  generate
    if (LIM_W < AW) begin : g_lim
      assign hi_new = |new_al[AW-1:LIM_W];
      assign hi_cur = |addr_q[AW-1:LIM_W];
    end else begin : g_nolim
      assign hi_new = 1'b0;
      assign hi_cur = 1'b0;
    end
  endgenerate

  assign fault_new_o = hi_new || (new_store_i && (new_al < VEC_LIM));
  assign fault_cur_o = hi_cur || (cur_store_i && (addr_q < VEC_LIM));
  assign cur_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= new_al;
    else if (step_i) addr_q <= addr_q + STEP;
  end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cp_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LIM_W     = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [2:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic [2:0]    cp_phase,
  input  logic [1:0]    cp_reply,
  output logic [DW-1:0] cp_wdata,
  input  logic [DW-1:0] cp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_abort,
  input  logic          req_reset_n,
  input  logic          req_fast_n,
  input  logic          req_norm_n,
  input  logic          mask_fast,
  input  logic          mask_norm,
  output logic          done,
  output logic [1:0]    res_code,
  output logic [1:0]    res_cause,
  output logic [DW-1:0] res_data
);
  localparam logic [DW-1:0] CC_MASK = {4'hF, {(DW-4){1'b0}}};

  seq_state_e    st, nxt;
  logic [2:0]    kind_q;
  logic [DW-1:0] src_q;
  logic          done_q;
  logic [1:0]    code_q, cause_q, pcause_q;
  logic [DW-1:0] data_q;

  logic          pend;
  logic [1:0]    cause;
  logic          fault_new, fault_cur;
  logic [AW-1:0] cur_addr;

  logic fin, ld_addr, step, cap_rd, cc_rd, set_pc;
  logic [1:0] fcode;
  logic new_is_mem;

  cp_pend_arb u_arb (
    .req_reset_n(req_reset_n), .req_fast_n(req_fast_n), .req_norm_n(req_norm_n),
    .mask_fast(mask_fast), .mask_norm(mask_norm),
    .pend_o(pend), .cause_o(cause)
  );

  cp_addr_unit #(.AW(AW), .LIM_W(LIM_W), .VEC_BYTES(VEC_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load_i(ld_addr), .addr_i(op_addr), .new_store_i(op_kind == K_STORE),
    .step_i(step), .cur_store_i(kind_q == K_STORE),
    .cur_o(cur_addr), .fault_new_o(fault_new), .fault_cur_o(fault_cur)
  );

  assign op_ready   = (st == ST_IDLE) && !done_q;
  assign new_is_mem = (op_kind == K_LOAD) || (op_kind == K_STORE);

  always_comb begin
    nxt = st; fin = 1'b0; fcode = RC_OK;
    ld_addr = 1'b0; step = 1'b0; cap_rd = 1'b0; cc_rd = 1'b0; set_pc = 1'b0;
    unique case (st)
      ST_IDLE: if (op_valid && op_ready) begin
        ld_addr = 1'b1;
        if (new_is_mem && fault_new) begin fin = 1'b1; fcode = RC_ABORT; end
        else nxt = ST_FIRST;
      end
      ST_FIRST, ST_BUSY: begin
        if (cp_reply == RP_BUSY) nxt = ST_WAIT;
        else if (cp_reply == RP_CANT) begin
          fin = 1'b1; fcode = RC_UNDEF; cc_rd = (kind_q == K_READ);
        end else begin
          case (kind_q)
            K_WRITE, K_READ, K_LOAD: nxt = ST_XFER;
            K_STORE: if (fault_cur) begin fin = 1'b1; fcode = RC_ABORT; end
                     else nxt = ST_DATA;
            default: fin = 1'b1;
          endcase
        end
      end
      ST_WAIT: if (pend) begin nxt = ST_INTR; set_pc = 1'b1; end
               else nxt = ST_BUSY;
      ST_INTR: begin fin = 1'b1; fcode = RC_INTR; end
      ST_XFER: begin
        if (kind_q == K_READ) begin cap_rd = 1'b1; nxt = ST_TAIL; end
        else if (kind_q == K_LOAD) nxt = ST_DATA;
        else fin = 1'b1;
      end
      ST_TAIL: fin = 1'b1;
      ST_DATA: begin
        if (mem_abort) begin fin = 1'b1; fcode = RC_ABORT; end
        else if (cp_reply == RP_INC) step = 1'b1;
        else fin = 1'b1;
      end
    endcase
    if (fin) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind_q <= K_INT; src_q <= '0; done_q <= 1'b0;
      code_q <= RC_OK; cause_q <= CZ_NONE; pcause_q <= CZ_NONE; data_q <= '0;
    end else begin
      st     <= nxt;
      done_q <= fin;
      if (ld_addr) begin kind_q <= op_kind; src_q <= op_wdata; end
      if (set_pc) pcause_q <= cause;
      if (cap_rd) data_q <= cp_rdata;
      else if (cc_rd) data_q <= CC_MASK;
      if (fin) begin
        code_q  <= fcode;
        cause_q <= (fcode == RC_INTR) ? pcause_q : CZ_NONE;
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_FIRST: cp_phase = PH_FIRST;
      ST_BUSY:  cp_phase = PH_BUSY;
      ST_INTR:  cp_phase = PH_INTR;
      ST_XFER:  cp_phase = PH_XFER;
      ST_DATA:  cp_phase = PH_DATA;
      default:  cp_phase = PH_IDLE;
    endcase
  end

  assign mem_req   = (st == ST_DATA);
  assign mem_we    = mem_req && (kind_q == K_STORE);
  assign mem_addr  = cur_addr;
  assign mem_wdata = cp_rdata;
  assign cp_wdata  = (st == ST_XFER && kind_q == K_WRITE) ? src_q :
                     (st == ST_DATA && kind_q == K_LOAD)  ? mem_rdata : '0;

  assign done      = done_q;
  assign res_code  = code_q;
  assign res_cause = cause_q;
  assign res_data  = data_q;
endmodule

// File: rtl/cp_seq_chk.sv
module cp_seq_chk
  import cp_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_reply,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_abort,
  input logic          req_reset_n,
  input logic          done,
  input logic [1:0]    res_code,
  input logic [1:0]    res_cause,
  input logic [DW-1:0] res_data
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase != PH_IDLE || done) |-> !op_ready);

  p_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> (cp_phase == PH_FIRST || done));

  p_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_reply == RP_BUSY)
      |=> cp_phase == PH_IDLE);

  p_busy_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == PH_BUSY) |-> $past(cp_phase) == PH_IDLE);

  p_intr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == PH_INTR) |=> (done && res_code == RC_INTR));

  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == PH_INTR && !$past(req_reset_n)) |=> res_cause == CZ_RESET);

  p_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_reply == RP_CANT)
      |=> (done && res_code == RC_UNDEF));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cp_reply == RP_INC && !mem_abort)
      |=> (mem_req && mem_addr == $past(mem_addr) + AW'(4)));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_abort) |=> (done && res_code == RC_ABORT));

  p_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done) && cp_phase == PH_IDLE && $past(cp_phase) == PH_IDLE)
      |-> ($stable(res_code) && $stable(res_cause) && $stable(res_data)));
endmodule

bind cp_handshake_seq cp_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .cp_phase(cp_phase), .cp_reply(cp_reply), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_abort(mem_abort), .req_reset_n(req_reset_n),
  .done(done), .res_code(res_code), .res_cause(res_cause), .res_data(res_data)
);

// File: tb/cp_handshake_seq_test.sv
module cp_handshake_seq_test;
  localparam int CLK_NS = 10;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        op_valid = 0, op_ready;
  logic [2:0]  op_kind = 0;
  logic [31:0] op_addr = 0, op_wdata = 0;
  logic [2:0]  cp_phase;
  logic [1:0]  cp_reply = 0;
  logic [31:0] cp_wdata, cp_rdata = 0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_abort = 0;
  logic        req_reset_n = 1, req_fast_n = 1, req_norm_n = 1;
  logic        mask_fast = 0, mask_norm = 0;
  logic        done;
  logic [1:0]  res_code, res_cause;
  logic [31:0] res_data;

  assign mem_rdata = mem_addr ^ KEY;

  cp_handshake_seq uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_addr(op_addr), .op_wdata(op_wdata),
    .cp_phase(cp_phase), .cp_reply(cp_reply), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_abort(mem_abort),
    .req_reset_n(req_reset_n), .req_fast_n(req_fast_n), .req_norm_n(req_norm_n),
    .mask_fast(mask_fast), .mask_norm(mask_norm),
    .done(done), .res_code(res_code), .res_cause(res_cause), .res_data(res_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] addr;
    logic [3:0]  nbusy;
    logic        cant;
    logic [3:0]  ninc;
    logic [2:0]  pend;   // [2] reset low, [1] fast low, [0] normal low
    logic [1:0]  mask;   // [1] fast mask, [0] normal mask
    logic [1:0]  ecode;
    logic [1:0]  ecause;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{3'd2, 32'h0000_0000, 4'd0, 1'b0, 4'd0, 3'b000, 2'b00, 2'd0, 2'd0},
    '{3'd0, 32'h0000_0000, 4'd2, 1'b0, 4'd0, 3'b000, 2'b00, 2'd0, 2'd0},
    '{3'd1, 32'h0000_0000, 4'd1, 1'b0, 4'd0, 3'b000, 2'b00, 2'd0, 2'd0},
    '{3'd1, 32'h0000_0000, 4'd1, 1'b1, 4'd0, 3'b000, 2'b00, 2'd1, 2'd0},
    '{3'd2, 32'h0000_0000, 4'd0, 1'b1, 4'd0, 3'b000, 2'b00, 2'd1, 2'd0},
    '{3'd3, 32'h0000_0100, 4'd0, 1'b0, 4'd3, 3'b000, 2'b00, 2'd0, 2'd0},
    '{3'd4, 32'h0000_0200, 4'd1, 1'b0, 4'd2, 3'b000, 2'b00, 2'd0, 2'd0},
    '{3'd2, 32'h0000_0000, 4'd3, 1'b0, 4'd0, 3'b001, 2'b00, 2'd3, 2'd3},
    '{3'd0, 32'h0000_0000, 4'd2, 1'b0, 4'd0, 3'b011, 2'b10, 2'd3, 2'd3},
    '{3'd0, 32'h0000_0000, 4'd1, 1'b0, 4'd0, 3'b011, 2'b00, 2'd3, 2'd2},
    '{3'd2, 32'h0000_0000, 4'd1, 1'b0, 4'd0, 3'b111, 2'b11, 2'd3, 2'd1},
    '{3'd2, 32'h0000_0000, 4'd2, 1'b0, 4'd0, 3'b011, 2'b11, 2'd0, 2'd0},
    '{3'd3, 32'h0400_0000, 4'd0, 1'b0, 4'd0, 3'b000, 2'b00, 2'd2, 2'd0},
    '{3'd4, 32'h0000_0010, 4'd0, 1'b0, 4'd0, 3'b000, 2'b00, 2'd2, 2'd0},
    '{3'd3, 32'h0000_0010, 4'd0, 1'b0, 4'd0, 3'b000, 2'b00, 2'd0, 2'd0},
    '{3'd2, 32'h0000_0000, 4'd0, 1'b0, 4'd0, 3'b001, 2'b00, 2'd0, 2'd0},
    '{3'd4, 32'h0000_0106, 4'd0, 1'b0, 4'd1, 3'b000, 2'b00, 2'd0, 2'd0}
  };

  int r_lat, r_first, r_busy, r_intr, r_xfer, r_data, st_cnt, st_bad;
  logic [31:0] xfer_wd, ld_sum, st_last;
  logic r_ready_done;

  task automatic run_op(input logic [2:0] kind, input logic [31:0] addr, input logic [31:0] wdata,
                        input logic [31:0] rdata, input int nbusy, input bit cant, input int ninc,
                        input logic [2:0] pend, input logic [1:0] mask, input int abort_at);
    int busy_left, inc_left;
    busy_left = nbusy; inc_left = ninc;
    r_lat = 0; r_first = 0; r_busy = 0; r_intr = 0; r_xfer = 0; r_data = 0;
    st_cnt = 0; st_bad = 0; xfer_wd = 0; ld_sum = 0; st_last = 0;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_kind = kind; op_addr = addr; op_wdata = wdata; cp_rdata = rdata;
    req_reset_n = !pend[2]; req_fast_n = !pend[1]; req_norm_n = !pend[0];
    mask_fast = mask[1]; mask_norm = mask[0];
    cp_reply = 2'd0; mem_abort = 0; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
    r_lat = 1;
    while (!done && r_lat < 300) begin
      cp_reply = 2'd0; mem_abort = 0;
      case (cp_phase)
        3'd1, 3'd2: begin
          if (cp_phase == 3'd1) r_first++; else r_busy++;
          if (busy_left > 0) begin cp_reply = 2'd1; busy_left--; end
          else cp_reply = cant ? 2'd2 : 2'd0;
        end
        3'd3: r_intr++;
        3'd4: begin r_xfer++; xfer_wd = cp_wdata; end
        3'd5: begin
          if (r_data == abort_at) mem_abort = 1;
          r_data++;
          if (kind == 3'd3) ld_sum = ld_sum + cp_wdata;
          if (mem_we) begin
            st_cnt++; st_last = mem_addr;
            if (mem_wdata !== rdata) st_bad++;
          end
          if (inc_left > 0) begin cp_reply = 2'd3; inc_left--; end
        end
        default: ;
      endcase
      @(negedge clk);
      r_lat++;
    end
    r_ready_done = op_ready;
    cp_reply = 2'd0; mem_abort = 0;
    req_reset_n = 1; req_fast_n = 1; req_norm_n = 1; mask_fast = 0; mask_norm = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", "reset done", {31'd0, done}, 32'd0);
    chk("R13", "reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R13", "reset code", {30'd0, res_code}, 32'd0);
    chk("R2", "reset phase", {29'd0, cp_phase}, 32'd0);
    chk("R1", "reset ready", {31'd0, op_ready}, 32'd1);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int exp_lat, exp_busy, exp_xfer, exp_data, extra;
      bit ok, intr, flt;
      logic [31:0] rd, base, sum;
      v = VT[i];
      rd = 32'hC0DE_0000 | 32'(i);
      run_op(v.kind, v.addr, 32'hBEEF_0000 | 32'(i), rd, int'(v.nbusy), v.cant,
             int'(v.ninc), v.pend, v.mask, 99);
      ok = (v.ecode == 2'd0); intr = (v.ecode == 2'd3); flt = (v.ecode == 2'd2);
      case (v.kind)
        3'd0: extra = 1;
        3'd1: extra = 2;
        3'd3: extra = 2 + int'(v.ninc);
        3'd4: extra = 1 + int'(v.ninc);
        default: extra = 0;
      endcase
      if (flt) exp_lat = 1;
      else if (intr) exp_lat = 4;
      else if (!ok) exp_lat = 2 + 2 * int'(v.nbusy);
      else exp_lat = 2 + 2 * int'(v.nbusy) + extra;
      exp_busy = (flt || intr) ? 0 : int'(v.nbusy);
      exp_xfer = (ok && (v.kind == 3'd0 || v.kind == 3'd1 || v.kind == 3'd3)) ? 1 : 0;
      exp_data = (ok && (v.kind == 3'd3 || v.kind == 3'd4)) ? int'(v.ninc) + 1 : 0;

      chk(intr ? "R4" : flt ? "R11" : ok ? "R2" : "R6", $sformatf("vec%0d code", i),
          {30'd0, res_code}, {30'd0, v.ecode});
      chk("R5", $sformatf("vec%0d cause", i), {30'd0, res_cause}, {30'd0, v.ecause});
      chk("R3", $sformatf("vec%0d latency", i), 32'(r_lat), 32'(exp_lat));
      chk("R3", $sformatf("vec%0d busy phases", i), 32'(r_busy), 32'(exp_busy));
      chk("R1", $sformatf("vec%0d first phases", i), 32'(r_first), flt ? 32'd0 : 32'd1);
      chk("R4", $sformatf("vec%0d intr phases", i), 32'(r_intr), intr ? 32'd1 : 32'd0);
      chk("R7", $sformatf("vec%0d xfer phases", i), 32'(r_xfer), 32'(exp_xfer));
      chk("R9", $sformatf("vec%0d data phases", i), 32'(r_data), 32'(exp_data));
      if (v.kind == 3'd1 && ok) chk("R8", $sformatf("vec%0d fetched", i), res_data, rd);
      if (v.kind == 3'd1 && v.ecode == 2'd1) chk("R6", $sformatf("vec%0d flag mask", i), res_data, 32'hF000_0000);
      if (v.kind == 3'd0 && ok) chk("R7", $sformatf("vec%0d sent word", i), xfer_wd, 32'hBEEF_0000 | 32'(i));
      base = {v.addr[31:2], 2'b00};
      if (v.kind == 3'd3 && ok) begin
        sum = 0;
        for (int k = 0; k <= int'(v.ninc); k++) sum = sum + ((base + 32'(4 * k)) ^ KEY);
        chk("R9", $sformatf("vec%0d load sum", i), ld_sum, sum);
      end
      if (v.kind == 3'd4 && ok) begin
        chk("R10", $sformatf("vec%0d store count", i), 32'(st_cnt), 32'(int'(v.ninc) + 1));
        chk("R10", $sformatf("vec%0d store last addr", i), st_last, base + 32'(4 * int'(v.ninc)));
        chk("R10", $sformatf("vec%0d store data", i), 32'(st_bad), 32'd0);
      end
    end

    // R12: abort on the second word of a load
    run_op(3'd3, 32'h0000_0300, 32'd0, 32'd0, 0, 1'b0, 4, 3'b000, 2'b00, 1);
    chk("R12", "load abort code", {30'd0, res_code}, 32'd2);
    chk("R12", "load abort words", 32'(r_data), 32'd2);
    chk("R12", "load abort latency", 32'(r_lat), 32'd5);

    // R12: abort on the first word of a store
    run_op(3'd4, 32'h0000_0400, 32'd0, 32'h1234_5678, 0, 1'b0, 2, 3'b000, 2'b00, 0);
    chk("R12", "store abort code", {30'd0, res_code}, 32'd2);
    chk("R12", "store abort latency", 32'(r_lat), 32'd3);

    // R1 / R13: ready low with done, pulse lasts one cycle, results held
    run_op(3'd1, 32'd0, 32'd0, 32'hA0A0_5555, 0, 1'b0, 0, 3'b000, 2'b00, 99);
    chk("R1", "ready during done", {31'd0, r_ready_done}, 32'd0);
    @(negedge clk);
    chk("R13", "done one cycle", {31'd0, done}, 32'd0);
    chk("R1", "ready after done", {31'd0, op_ready}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R13", "result held", res_data, 32'hA0A0_5555);

    finish_run();
  end
endmodule